// File: doc/BRIEF.md
# Edge-triggered GPIO interrupt controller

The block watches groups of 32 general-purpose pin inputs, brings each pin into the local clock domain, and detects rising and falling transitions on it. Each pin has an independent rising-edge enable and falling-edge enable. Every enabled transition latches a sticky bit in the status register of that pin's group. Software clears these bits by writing ones to them.

Each 32-pin group feeds two interrupt lines. One line collects the lower sixteen status bits and the other collects the upper sixteen. A global bank-enable register gates every line, and every line is registered.

The edge enables are never written directly. Software changes them through paired write-one aliases: one alias sets enable bits and the other clears them, so a read-modify-write is never needed. All registers sit on a simple 32-bit register bus. A write takes effect on the clock edge where `reg_wr_i` is high. Read data is a combinational function of the address.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset, every edge enable, every status bit and every bank enable reads 0, and every `irq_o` bit is 0.
- R2: For group k, writing to base+0x14 sets the rising-enable bits where the data is 1. Writing to base+0x18 clears them where the data is 1. Zero bits leave the enables unchanged. A read at either address returns the rising enables.
- R3: For group k, base+0x1C and base+0x20 set and clear the falling-enable bits with the same write-one rules as R2. A read at either address returns the falling enables.
- R4: A low-to-high transition on a pin whose rising enable is 1 sets that pin's status bit. A high-to-low transition does so when the falling enable is 1. A transition whose type is not enabled sets nothing.
- R5: A pin with both enables set latches a status bit on either transition.
- R6: Writing to base+0x24 clears each status bit where the data is 1 and leaves bits written 0 unchanged. A read at base+0x24 returns the status.
- R7: If an enabled transition and a clearing write hit the same status bit in the same cycle, the bit remains 1.
- R8: Status bits 15:0 of group k drive `irq_o[2k]`, and bits 31:16 drive `irq_o[2k+1]`.
- R9: Bank-enable register at 0x08 holds bit b for line b. `irq_o[b]` equals, one cycle later, bank-enable bit b ANDed with the OR of that line's sixteen status bits. A read at 0x08 returns the enables.
- R10: Group k's register base is 0x10 + 0x28*k.
- R11: With two synchronizer stages, a transition driven before clock edge 1 appears in status after edge 3 and on `irq_o` after edge 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pins_i | input | 32*NUM_SETS | Asynchronous pin inputs |
| reg_addr_i | input | 8 | Register byte address |
| reg_wr_i | input | 1 | Write strobe |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i (0 for unmapped addresses) |
| irq_o | output | 2*NUM_SETS | Registered per-bank interrupt lines |

## Verification
The bench builds the block with NUM_SETS=2 and SYNC_STAGES=2. Two groups exercise the second base address at 0x38 and four interrupt lines, so each line's placement and gating can be checked against its neighbours. Two synchronizer stages give the exact edge-to-status and edge-to-interrupt latencies that the same-cycle collision test aims at. Random pin toggles and random alias writes then run against a reference model kept in the bench.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int unsigned ADDR_W        = 8;
  localparam int unsigned REG_W         = 32;
  localparam int unsigned BANK_PINS     = 16;
  localparam int unsigned BANKS_PER_SET = REG_W / BANK_PINS;

  localparam logic [ADDR_W-1:0] OFS_BANK_EN  = 8'h08;
  localparam logic [ADDR_W-1:0] SET_BASE     = 8'h10;
  localparam logic [ADDR_W-1:0] SET_STRIDE   = 8'h28;
  localparam logic [ADDR_W-1:0] OFS_RISE_SET = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_RISE_CLR = 8'h18;
  localparam logic [ADDR_W-1:0] OFS_FALL_SET = 8'h1C;
  localparam logic [ADDR_W-1:0] OFS_FALL_CLR = 8'h20;
  localparam logic [ADDR_W-1:0] OFS_STAT     = 8'h24;

  function automatic logic [ADDR_W-1:0] set_addr(input int unsigned k,
                                                 input logic [ADDR_W-1:0] ofs);
    logic [ADDR_W-1:0] base;
    base = SET_BASE + ADDR_W'(k) * SET_STRIDE;
    return base + ofs;
  endfunction
endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q[0] <= '0;
    else         stage_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else         stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_irq_pin_set.sv
module gpio_irq_pin_set #(
  parameter int unsigned PINS = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [PINS-1:0] pin_i,
  input  logic [PINS-1:0] rise_set_i,
  input  logic [PINS-1:0] rise_clr_i,
  input  logic [PINS-1:0] fall_set_i,
  input  logic [PINS-1:0] fall_clr_i,
  input  logic [PINS-1:0] stat_clr_i,
  output logic [PINS-1:0] rise_en_o,
  output logic [PINS-1:0] fall_en_o,
  output logic [PINS-1:0] stat_o,
  output logic [PINS-1:0] hit_o
);
  logic [PINS-1:0] prev_q, rise_en_q, fall_en_q, stat_q;
  logic [PINS-1:0] rose, fell;

  assign rose  = pin_i & ~prev_q;
  assign fell  = ~pin_i & prev_q;
  assign hit_o = (rose & rise_en_q) | (fell & fall_en_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q    <= '0;
      rise_en_q <= '0;
      fall_en_q <= '0;
      stat_q    <= '0;
    end else begin
      prev_q    <= pin_i;
      rise_en_q <= (rise_en_q | rise_set_i) & ~rise_clr_i;
      fall_en_q <= (fall_en_q | fall_set_i) & ~fall_clr_i;
      // a fresh event outranks a clear in the same cycle
      stat_q    <= (stat_q & ~stat_clr_i) | hit_o;
    end
  end

  assign rise_en_o = rise_en_q;
  assign fall_en_o = fall_en_q;
  assign stat_o    = stat_q;
endmodule

// File: rtl/gpio_irq_bank_gate.sv
module gpio_irq_bank_gate #(
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned BANK_PINS = 16
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [NUM_BANKS*BANK_PINS-1:0] stat_i,
  input  logic [NUM_BANKS-1:0]           en_i,
  output logic [NUM_BANKS-1:0]           irq_o
);
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) irq_o[b] <= 1'b0;
      else         irq_o[b] <= en_i[b] & (|stat_i[b*BANK_PINS +: BANK_PINS]);
    end
  end
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NUM_SETS    = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [NUM_SETS*REG_W-1:0]     pins_i,
  input  logic [ADDR_W-1:0]             reg_addr_i,
  input  logic                          reg_wr_i,
  input  logic [REG_W-1:0]              reg_wdata_i,
  output logic [REG_W-1:0]              reg_rdata_o,
  output logic [NUM_SETS*BANKS_PER_SET-1:0] irq_o
);
  localparam int unsigned NUM_PINS  = NUM_SETS * REG_W;
  localparam int unsigned NUM_BANKS = NUM_SETS * BANKS_PER_SET;

  logic [NUM_PINS-1:0] pins_sync;
  logic [NUM_SETS-1:0][REG_W-1:0] set_rise_en, set_fall_en, set_stat, set_hit;
  logic [NUM_SETS-1:0][REG_W-1:0] rset_mask, rclr_mask, fset_mask, fclr_mask, sclr_mask;
  logic [NUM_PINS-1:0]  all_stat, all_hit, all_sclr, all_ren, all_rset, all_fen, all_fset;
  logic [NUM_BANKS-1:0] bank_en_q;

  gpio_irq_sync #(.W(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pins_i),
    .q_o   (pins_sync)
  );

  for (genvar k = 0; k < NUM_SETS; k++) begin : g_set
    assign rset_mask[k] = (reg_wr_i && reg_addr_i == set_addr(k, OFS_RISE_SET)) ? reg_wdata_i : '0;
    assign rclr_mask[k] = (reg_wr_i && reg_addr_i == set_addr(k, OFS_RISE_CLR)) ? reg_wdata_i : '0;
    assign fset_mask[k] = (reg_wr_i && reg_addr_i == set_addr(k, OFS_FALL_SET)) ? reg_wdata_i : '0;
    assign fclr_mask[k] = (reg_wr_i && reg_addr_i == set_addr(k, OFS_FALL_CLR)) ? reg_wdata_i : '0;
    assign sclr_mask[k] = (reg_wr_i && reg_addr_i == set_addr(k, OFS_STAT))     ? reg_wdata_i : '0;

    gpio_irq_pin_set #(.PINS(REG_W)) u_set (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .pin_i     (pins_sync[k*REG_W +: REG_W]),
      .rise_set_i(rset_mask[k]),
      .rise_clr_i(rclr_mask[k]),
      .fall_set_i(fset_mask[k]),
      .fall_clr_i(fclr_mask[k]),
      .stat_clr_i(sclr_mask[k]),
      .rise_en_o (set_rise_en[k]),
      .fall_en_o (set_fall_en[k]),
      .stat_o    (set_stat[k]),
      .hit_o     (set_hit[k])
    );
  end

  assign all_stat = set_stat;
  assign all_hit  = set_hit;
  assign all_sclr = sclr_mask;
  assign all_ren  = set_rise_en;
  assign all_rset = rset_mask;
  assign all_fen  = set_fall_en;
  assign all_fset = fset_mask;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                   bank_en_q <= '0;
    else if (reg_wr_i && reg_addr_i == OFS_BANK_EN) bank_en_q <= reg_wdata_i[NUM_BANKS-1:0];
  end

  gpio_irq_bank_gate #(.NUM_BANKS(NUM_BANKS), .BANK_PINS(BANK_PINS)) u_gate (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .stat_i(all_stat),
    .en_i  (bank_en_q),
    .irq_o (irq_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i == OFS_BANK_EN) reg_rdata_o = REG_W'(bank_en_q);
    for (int unsigned k = 0; k < NUM_SETS; k++) begin
      if (reg_addr_i == set_addr(k, OFS_RISE_SET) || reg_addr_i == set_addr(k, OFS_RISE_CLR))
        reg_rdata_o = set_rise_en[k];
      if (reg_addr_i == set_addr(k, OFS_FALL_SET) || reg_addr_i == set_addr(k, OFS_FALL_CLR))
        reg_rdata_o = set_fall_en[k];
      if (reg_addr_i == set_addr(k, OFS_STAT))
        reg_rdata_o = set_stat[k];
    end
  end
endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk #(
  parameter int unsigned NUM_SETS = 2
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic [NUM_SETS*2-1:0]   irq_i,
  input logic [NUM_SETS*2-1:0]   bank_en_i,
  input logic [NUM_SETS*32-1:0]  stat_i,
  input logic [NUM_SETS*32-1:0]  hit_i,
  input logic [NUM_SETS*32-1:0]  sclr_i,
  input logic [NUM_SETS*32-1:0]  ren_i,
  input logic [NUM_SETS*32-1:0]  rset_i,
  input logic [NUM_SETS*32-1:0]  fen_i,
  input logic [NUM_SETS*32-1:0]  fset_i
);
  a_r7_event_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(hit_i) & ~stat_i) == '0);

  a_r6_clear_takes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(sclr_i) & ~$past(hit_i) & stat_i) == '0);

  a_r6_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(stat_i) & ~$past(sclr_i) & ~stat_i) == '0);

  a_r4_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_i & ~$past(stat_i) & ~$past(hit_i)) == '0);

  a_r2_rise_only_by_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ren_i & ~$past(ren_i) & ~$past(rset_i)) == '0);

  a_r3_fall_only_by_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fen_i & ~$past(fen_i) & ~$past(fset_i)) == '0);

  for (genvar b = 0; b < NUM_SETS*2; b++) begin : g_line
    // R8 placement and R9 gating with one cycle of delay
    a_r9_line_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_i[b] == $past(bank_en_i[b] && (|stat_i[b*16 +: 16])));
  end
endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.NUM_SETS(NUM_SETS)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .irq_i    (irq_o),
  .bank_en_i(bank_en_q),
  .stat_i   (all_stat),
  .hit_i    (all_hit),
  .sclr_i   (all_sclr),
  .ren_i    (all_ren),
  .rset_i   (all_rset),
  .fen_i    (all_fen),
  .fset_i   (all_fset)
);

// File: tb/gpio_irq_ctrl_bench.sv
module gpio_irq_ctrl_bench;
  localparam int NS = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] pins = '0;
  logic [7:0]  addr = '0;
  logic        wr = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  irq;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  logic [31:0] m_ren [NS];
  logic [31:0] m_fen [NS];
  logic [31:0] m_st  [NS];
  logic [3:0]  m_ben;

  always #4 clk = ~clk;

  gpio_irq_ctrl #(.NUM_SETS(NS), .SYNC_STAGES(2)) u_gpio_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .pins_i(pins), .reg_addr_i(addr),
    .reg_wr_i(wr), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq)
  );

  function automatic logic [7:0] sa(input int k, input logic [7:0] ofs);
    return 8'h10 + 8'(k) * 8'h28 + ofs;
  endfunction

  function automatic logic [3:0] exp_irq();
    logic [3:0] r;
    for (int b = 0; b < 4; b++) r[b] = m_ben[b] & (|m_st[b/2][(b%2)*16 +: 16]);
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic drive_pins(input logic [63:0] nv);
    for (int k = 0; k < NS; k++) begin
      logic [31:0] o, n;
      o = pins[k*32 +: 32]; n = nv[k*32 +: 32];
      m_st[k] |= ((n & ~o) & m_ren[k]) | ((o & ~n) & m_fen[k]);
    end
    @(negedge clk); pins = nv;
  endtask

  task automatic check_all();
    logic [31:0] d;
    for (int k = 0; k < NS; k++) begin
      rd_reg(sa(k, 8'h24), d); chk("R4/R5/R6 status", d, m_st[k]);
      rd_reg(sa(k, 8'h18), d); chk("R2/R10 rise enables", d, m_ren[k]);
      rd_reg(sa(k, 8'h1C), d); chk("R3/R10 fall enables", d, m_fen[k]);
    end
    rd_reg(8'h08, d); chk("R9 bank enables", d, {28'd0, m_ben});
    chk("R8/R9 irq lines", {28'd0, irq}, {28'd0, exp_irq()});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd1234));
    for (int k = 0; k < NS; k++) begin m_ren[k] = '0; m_fen[k] = '0; m_st[k] = '0; end
    m_ben = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int k = 0; k < NS; k++) begin
      rd_reg(sa(k, 8'h24), d); chk("R1 status", d, 0);
      rd_reg(sa(k, 8'h14), d); chk("R1 rise enables", d, 0);
      rd_reg(sa(k, 8'h20), d); chk("R1 fall enables", d, 0);
    end
    rd_reg(8'h08, d); chk("R1 bank enables", d, 0);
    chk("R1 irq", {28'd0, irq}, 0);

    // R11 latency: enable pin 3 rising and bank 0
    wr_reg(sa(0, 8'h14), 32'h8); m_ren[0] = 32'h8;
    wr_reg(8'h08, 32'h1); m_ben = 4'h1;
    drive_pins(64'h8);                              // N0
    rd_reg(sa(0, 8'h24), d);                        // N1
    rd_reg(sa(0, 8'h24), d); chk("R11 status before edge 3", d, 0);
    rd_reg(sa(0, 8'h24), d); chk("R11 status after edge 3", d, 32'h8);
    chk("R11 irq before edge 4", {31'd0, irq[0]}, 0);
    @(negedge clk); chk("R11 irq after edge 4", {31'd0, irq[0]}, 1);
    check_all();

    // R4 falling not enabled: no effect
    drive_pins(64'h0); repeat (4) @(negedge clk);
    check_all();

    // R7 collision: rise again while clearing bit 3 in the same cycle
    @(negedge clk); pins = 64'h8;                   // N0
    @(negedge clk);                                 // N1
    @(negedge clk); addr = sa(0, 8'h24); wdata = 32'h8; wr = 1'b1; // N2
    @(negedge clk); wr = 1'b0;                      // N3
    rd_reg(sa(0, 8'h24), d); chk("R7 event beats clear", d, 32'h8);
    // R6 plain clear; zeros leave others
    wr_reg(sa(0, 8'h24), 32'hFFFF_FFF7);
    rd_reg(sa(0, 8'h24), d); chk("R6 zero bits untouched", d, 32'h8);
    wr_reg(sa(0, 8'h24), 32'h8); m_st[0] = '0;
    @(negedge clk); check_all();

    // R5 both edges on pin 20 (bank 1), R8 placement, R9 gate
    wr_reg(sa(0, 8'h14), 32'h0010_0000); m_ren[0] |= 32'h0010_0000;
    wr_reg(sa(0, 8'h1C), 32'h0010_0000); m_fen[0] |= 32'h0010_0000;
    wr_reg(8'h08, 32'h2); m_ben = 4'h2;
    drive_pins(pins | 64'h0010_0000); repeat (4) @(negedge clk);
    check_all();
    chk("R8 upper half on line 1", {28'd0, irq}, 32'h2);
    wr_reg(sa(0, 8'h24), 32'h0010_0000); m_st[0] = '0;
    drive_pins(pins & ~64'h0010_0000); repeat (4) @(negedge clk);
    check_all();
    chk("R5 falling latched", m_st[0], 32'h0010_0000);
    wr_reg(8'h08, 32'h0); m_ben = 4'h0; @(negedge clk);
    chk("R9 gated off", {28'd0, irq}, 0);
    // R2/R3 clear aliases
    wr_reg(sa(0, 8'h18), 32'hFFFF_FFFF); m_ren[0] = '0;
    wr_reg(sa(0, 8'h20), 32'h0010_0000); m_fen[0] = '0;
    @(negedge clk); check_all();
    // R10 second group base at 0x38
    wr_reg(8'h4C, 32'h0001_0001); m_ren[1] = 32'h0001_0001;
    rd_reg(8'h50, d); chk("R10 group 1 rise alias", d, 32'h0001_0001);

    for (int i = 0; i < 120; i++) begin
      int k;
      logic [31:0] r;
      k = $urandom_range(0, NS - 1);
      r = $urandom;
      case ($urandom_range(0, 6))
        0, 1: begin
          drive_pins(pins ^ ({$urandom, $urandom} & {$urandom, $urandom}));
          repeat (4) @(negedge clk);
        end
        2: begin wr_reg(sa(k, 8'h14), r); m_ren[k] |= r;  @(negedge clk); end
        3: begin wr_reg(sa(k, 8'h18), r); m_ren[k] &= ~r; @(negedge clk); end
        4: begin wr_reg(sa(k, 8'h1C), r); m_fen[k] |= r;  @(negedge clk); end
        5: begin wr_reg(sa(k, 8'h20), r); m_fen[k] &= ~r; @(negedge clk); end
        default: begin
          if (r[31]) begin wr_reg(8'h08, r); m_ben = r[3:0]; end
          else begin wr_reg(sa(k, 8'h24), r); m_st[k] &= ~r; end
          @(negedge clk);
        end
      endcase
      check_all();
    end
    summary();
  end
endmodule